// File: doc/BRIEF.md
# Video Sync and Field Router

This block picks the vertical sync and field signals that pass between a video capture port, an external sync pin and a display controller. Three encoded select inputs each choose one output's source. The pin-side sync can come from the controller vsync, its inverse, a software pulse or a constant low. The field sent to the controller can come from the field input or from the low bit of the page being written, either one plain or inverted. The vsync sent to the controller can come from the incoming pin sync, vblank or field, each plain or inverted, or from a match between the current line and a target line.

A one-cycle trigger input starts a pulse of fixed width. The pulse is visible on its own output and can also be routed to the pin. Every output is registered, so each output follows its inputs with exactly one clock of latency.

Top module: `vsync_field_router`

## Requirements
- R1: Reset drives `pin_sync_out`, `field_to_dc`, `vsync_to_dc` and `sw_pulse` low and clears the pulse counter.
- R2: When `pin_sel` is 3'b000 or any value from 3'b100 to 3'b111, `pin_sync_out` is 0.
- R3: When `pin_sel` is 3'b001, `pin_sync_out` equals `dc_vsync_in`. When it is 3'b010, `pin_sync_out` equals the inverse of `dc_vsync_in`.
- R4: When `pin_sel` is 3'b011, `pin_sync_out` is `sw_pulse` delayed by one clock.
- R5: When `fld_sel` is 2'b00, `field_to_dc` equals `field_in`. When it is 2'b01, `field_to_dc` equals the inverse of `field_in`.
- R6: When `fld_sel` is 2'b10, `field_to_dc` equals `page_lsb_in`. When it is 2'b11, `field_to_dc` equals the inverse of `page_lsb_in`.
- R7: When `dcv_sel` is 3'b000 or 3'b001, `vsync_to_dc` equals `pin_sync_in`, plain or inverted respectively.
- R8: `dcv_sel` codes 3'b010 and 3'b011 select `vblank_in` plain and inverted. Codes 3'b100 and 3'b101 select `field_in` plain and inverted.
- R9: When `dcv_sel` is 3'b110, `vsync_to_dc` is 1 exactly when `cur_line` equals `tgt_line`. When it is 3'b111, `vsync_to_dc` is 0.
- R10: A high `sw_trig` sampled while `sw_pulse` is low makes `sw_pulse` rise at that clock edge. `sw_pulse` then stays high for exactly PULSE_LEN (default 32) cycles and returns low.
- R11: A high `sw_trig` sampled while `sw_pulse` is high has no effect. The running pulse is neither restarted nor stretched.
- R12: Each routed output takes the value its selected source had at the previous rising clock edge. A change at an input does not appear at an output before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_sel | input | 3 | Source select for the pin sync output |
| fld_sel | input | 2 | Source select for the field sent to the controller |
| dcv_sel | input | 3 | Source select for the vsync sent to the controller |
| sw_trig | input | 1 | Software pulse trigger |
| pin_sync_in | input | 1 | Sync arriving from the external pin |
| dc_vsync_in | input | 1 | Vsync from the display controller |
| vblank_in | input | 1 | Vertical blanking indicator |
| field_in | input | 1 | Field indicator |
| page_lsb_in | input | 1 | Low bit of the page being written |
| cur_line | input | LINE_W | Current line number |
| tgt_line | input | LINE_W | Target line number |
| pin_sync_out | output | 1 | Sync driven to the pin |
| field_to_dc | output | 1 | Field sent to the controller |
| vsync_to_dc | output | 1 | Vsync sent to the controller |
| sw_pulse | output | 1 | Software sync pulse |

## Verification
The bench goes through every code of all three selects, with both polarities of each source. A decoder that mixes up the inverted codes, or that lets the undefined pin codes leak a signal, shows a wrong level on some output. The pulse width is counted cycle by cycle, so an off-by-one counter shows up as 31 or 33 high cycles. A second trigger is sent in the middle of a pulse and another on its last high cycle; a design that restarts the pulse on a trigger would show a stretched pulse. Latency is probed between edges, which exposes any combinational path from input to output, and the line-match source is tried with equal lines and with lines that differ only in the top bit.

// File: rtl/vsync_field_router.sv
module vsync_field_router #(
  parameter int LINE_W    = 11,
  parameter int PULSE_LEN = 32,
  localparam int CNT_W    = $clog2(PULSE_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        pin_sel,
  input  logic [1:0]        fld_sel,
  input  logic [2:0]        dcv_sel,
  input  logic              sw_trig,
  input  logic              pin_sync_in,
  input  logic              dc_vsync_in,
  input  logic              vblank_in,
  input  logic              field_in,
  input  logic              page_lsb_in,
  input  logic [LINE_W-1:0] cur_line,
  input  logic [LINE_W-1:0] tgt_line,
  output logic              pin_sync_out,
  output logic              field_to_dc,
  output logic              vsync_to_dc,
  output logic              sw_pulse
);

  logic [CNT_W-1:0] cnt_q;
  logic             pls_q;
  logic             pin_d, fld_d, dcv_d;
  logic             line_hit;
  logic             fire;

  assign line_hit = (cur_line == tgt_line);
  assign fire     = sw_trig && !pls_q;
  assign sw_pulse = pls_q;

  always_comb begin
    unique case (pin_sel)
      3'b001:  pin_d = dc_vsync_in;
      3'b010:  pin_d = !dc_vsync_in;
      3'b011:  pin_d = pls_q;
      default: pin_d = 1'b0;
    endcase
  end

  always_comb begin
    unique case (fld_sel)
      2'b00:   fld_d = field_in;
      2'b01:   fld_d = !field_in;
      2'b10:   fld_d = page_lsb_in;
      default: fld_d = !page_lsb_in;
    endcase
  end

  always_comb begin
    unique case (dcv_sel)
      3'b000:  dcv_d = pin_sync_in;
      3'b001:  dcv_d = !pin_sync_in;
      3'b010:  dcv_d = vblank_in;
      3'b011:  dcv_d = !vblank_in;
      3'b100:  dcv_d = field_in;
      3'b101:  dcv_d = !field_in;
      3'b110:  dcv_d = line_hit;
      default: dcv_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pls_q <= 1'b0;
    end else if (fire) begin
      cnt_q <= CNT_W'(PULSE_LEN - 1);
      pls_q <= 1'b1;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      pls_q <= (cnt_q != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_sync_out <= 1'b0;
      field_to_dc  <= 1'b0;
      vsync_to_dc  <= 1'b0;
    end else begin
      pin_sync_out <= pin_d;
      field_to_dc  <= fld_d;
      vsync_to_dc  <= dcv_d;
    end
  end

endmodule

// File: rtl/vsync_field_router_chk.sv
module vsync_field_router_chk #(
  parameter int LINE_W    = 11,
  parameter int PULSE_LEN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        pin_sel,
  input logic [1:0]        fld_sel,
  input logic [2:0]        dcv_sel,
  input logic              dc_vsync_in,
  input logic              page_lsb_in,
  input logic [LINE_W-1:0] cur_line,
  input logic [LINE_W-1:0] tgt_line,
  input logic              pin_sync_out,
  input logic              field_to_dc,
  input logic              vsync_to_dc,
  input logic              sw_pulse
);

  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)        run_len <= 0;
    else if (sw_pulse) run_len <= run_len + 1;
    else               run_len <= 0;
  end

  // R2
  pin_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_sel == 3'b000 || pin_sel[2]) |=> !pin_sync_out);

  // R3
  pin_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_sel == 3'b001) |=> (pin_sync_out == $past(dc_vsync_in)));

  // R4
  pin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_sel == 3'b011) |=> (pin_sync_out == $past(sw_pulse)));

  // R6
  fld_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_sel == 2'b10) |=> (field_to_dc == $past(page_lsb_in)));

  // R9
  line_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dcv_sel == 3'b110) |=> (vsync_to_dc == ($past(cur_line) == $past(tgt_line))));

  // R10
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_pulse) |-> (run_len == PULSE_LEN));

  // R11
  no_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_pulse |-> (run_len < PULSE_LEN));

endmodule

bind vsync_field_router vsync_field_router_chk #(.LINE_W(LINE_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_sel(pin_sel), .fld_sel(fld_sel), .dcv_sel(dcv_sel),
  .dc_vsync_in(dc_vsync_in), .page_lsb_in(page_lsb_in), .cur_line(cur_line),
  .tgt_line(tgt_line), .pin_sync_out(pin_sync_out), .field_to_dc(field_to_dc),
  .vsync_to_dc(vsync_to_dc), .sw_pulse(sw_pulse)
);

// File: tb/vsync_field_router_tb.sv
module vsync_field_router_tb;

  localparam int LW  = 11;
  localparam int PL  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] pin_sel = '0;
  logic [1:0] fld_sel = '0;
  logic [2:0] dcv_sel = '0;
  logic sw_trig = 1'b0;
  logic pin_sync_in = 1'b0, dc_vsync_in = 1'b0, vblank_in = 1'b0;
  logic field_in = 1'b0, page_lsb_in = 1'b0;
  logic [LW-1:0] cur_line = '0, tgt_line = '0;
  logic pin_sync_out, field_to_dc, vsync_to_dc, sw_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = !clk;

  vsync_field_router #(.LINE_W(LW), .PULSE_LEN(PL)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_sel(pin_sel), .fld_sel(fld_sel), .dcv_sel(dcv_sel),
    .sw_trig(sw_trig), .pin_sync_in(pin_sync_in), .dc_vsync_in(dc_vsync_in),
    .vblank_in(vblank_in), .field_in(field_in), .page_lsb_in(page_lsb_in),
    .cur_line(cur_line), .tgt_line(tgt_line), .pin_sync_out(pin_sync_out),
    .field_to_dc(field_to_dc), .vsync_to_dc(vsync_to_dc), .sw_pulse(sw_pulse)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R1 pin", pin_sync_out, 1'b0);
    chk("R1 field", field_to_dc, 1'b0);
    chk("R1 vsync", vsync_to_dc, 1'b0);
    chk("R1 pulse", sw_pulse, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic test_pin_sel();
    for (int s = 0; s < 8; s++) begin
      for (int v = 0; v < 2; v++) begin
        logic e;
        @(negedge clk);
        pin_sel = 3'(s);
        dc_vsync_in = v[0];
        @(negedge clk);
        e = (s == 1) ? v[0] : (s == 2) ? !v[0] : 1'b0;
        if (s == 1 || s == 2) chk("R3 pin vsync", pin_sync_out, e);
        else if (s != 3)      chk("R2 pin zero", pin_sync_out, e);
      end
    end
  endtask

  task automatic test_fld_sel();
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 4; v++) begin
        @(negedge clk);
        fld_sel = 2'(s);
        field_in = v[0];
        page_lsb_in = v[1];
        @(negedge clk);
        case (s)
          0: chk("R5 field", field_to_dc, v[0]);
          1: chk("R5 field inv", field_to_dc, !v[0]);
          2: chk("R6 page", field_to_dc, v[1]);
          default: chk("R6 page inv", field_to_dc, !v[1]);
        endcase
      end
    end
  endtask

  task automatic test_dcv_sel();
    for (int s = 0; s < 8; s++) begin
      for (int v = 0; v < 8; v++) begin
        @(negedge clk);
        dcv_sel = 3'(s);
        pin_sync_in = v[0];
        vblank_in = v[1];
        field_in = v[2];
        cur_line = 11'd500;
        tgt_line = v[0] ? 11'd500 : (v[1] ? 11'd1524 : 11'd501);
        @(negedge clk);
        case (s)
          0: chk("R7 pin", vsync_to_dc, v[0]);
          1: chk("R7 pin inv", vsync_to_dc, !v[0]);
          2: chk("R8 vblank", vsync_to_dc, v[1]);
          3: chk("R8 vblank inv", vsync_to_dc, !v[1]);
          4: chk("R8 field", vsync_to_dc, v[2]);
          5: chk("R8 field inv", vsync_to_dc, !v[2]);
          6: chk("R9 line match", vsync_to_dc, v[0]);
          default: chk("R9 zero", vsync_to_dc, 1'b0);
        endcase
      end
    end
  endtask

  task automatic test_latency();
    @(negedge clk);
    pin_sel = 3'b001;
    dc_vsync_in = 1'b0;
    fld_sel = 2'b00;
    field_in = 1'b0;
    @(negedge clk);
    dc_vsync_in = 1'b1;
    field_in = 1'b1;
    #1;
    chk("R12 pin before edge", pin_sync_out, 1'b0);
    chk("R12 field before edge", field_to_dc, 1'b0);
    @(negedge clk);
    chk("R12 pin after edge", pin_sync_out, 1'b1);
    chk("R12 field after edge", field_to_dc, 1'b1);
  endtask

  task automatic test_pulse();
    int hi = 0;
    int pin_hi = 0;
    @(negedge clk);
    pin_sel = 3'b011;
    @(negedge clk);
    chk("R10 idle", sw_pulse, 1'b0);
    sw_trig = 1'b1;
    @(negedge clk);
    sw_trig = 1'b0;
    chk("R10 rise", sw_pulse, 1'b1);
    chk("R4 pin lags", pin_sync_out, 1'b0);
    for (int i = 0; i < 40; i++) begin
      if (sw_pulse) hi++;
      if (pin_sync_out) pin_hi++;
      if (i == PL - 1) chk("R10 last high", sw_pulse, 1'b1);
      if (i == PL)     chk("R10 falls", sw_pulse, 1'b0);
      if (i == PL)     chk("R4 pin last", pin_sync_out, 1'b1);
      @(negedge clk);
    end
    chk_int("R10 width", hi, PL);
    chk_int("R4 pin width", pin_hi, PL);
  endtask

  task automatic test_retrigger();
    int hi = 0;
    @(negedge clk);
    sw_trig = 1'b1;
    @(negedge clk);
    sw_trig = 1'b0;
    for (int i = 0; i < 45; i++) begin
      if (sw_pulse) hi++;
      sw_trig = (i == 10 || i == PL - 1);
      @(negedge clk);
    end
    sw_trig = 1'b0;
    chk_int("R11 width with retrigger", hi, PL);
    chk("R11 stays low", sw_pulse, 1'b0);
  endtask

  initial begin
    test_reset();
    test_pin_sel();
    test_fld_sel();
    test_dcv_sel();
    test_latency();
    test_pulse();
    test_retrigger();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule